// File: doc/BRIEF.md
# MDIO management command interface

This block is the management side of an Ethernet MAC. A processor sets up a small bank of registers over a plain register bus. It writes a 16-bit value into a write-data register, then writes one command word. That word names a PHY, a register inside that PHY, an operation, and a start bit. The block carries out the read or write against the named PHY register in the clock edge that accepts the command word. Read results land in a read-data register, which can be read back on the next cycle. The serial pin protocol is not modelled, so every transaction takes one cycle and the command register always reports ready.

One emulated PHY is built in and answers at a parameterised PHY address. This lets the block run on its own. Any other PHY address behaves as an empty slot. The emulated PHY holds 32 registers of 16 bits. A few of its registers are computed rather than stored: the status register depends on a link input, and the partner-ability and diagnostic registers are derived from the PHY's own advertisement register.

Top module: `mdio_mgmt_top`

## Requirements
- R1: A CPU write to the command register (bus word 1) with bit 11 (start) set and bits 15:14 (operation) equal to 1 stores the write-data register into the PHY register chosen by bits 20:16, in the PHY chosen by bits 28:24.
- R2: A started command with operation 2 loads the read-data register (bus word 3) from the selected PHY register. The new value is readable in the cycle after the command write.
- R3: If the start bit is clear, or the operation is 0 or 3, no transaction happens: the read-data register and the PHY registers keep their values.
- R4: A read from a PHY address other than the attached one returns 0xFFFF. A write to such an address changes nothing.
- R5: Reading the command register returns the last word written to it, with bit 7 (ready) forced to 1. Its reset value therefore reads as 0x00000080.
- R6: The configuration register (bus word 0) keeps only bits 6:0 of a write. `cfg_err_o` is high whenever the stored bit 6 (enable) is 1 and the stored bits 5:0 (divider) are zero.
- R7: After reset, the emulated PHY holds 0x3100 in register 0, 0x0300 in register 2, 0xE400 in register 3, 0x01E1 in register 4, and 0 in every other stored register.
- R8: Every write to the emulated PHY leaves bits 15 and 9 of its register 0 cleared, including a write that targets register 0 itself.
- R9: Register 1 reads as 0x782E while `phy_link_i` is high, and as 0 while it is low.
- R10: Register 5 reads as 0x4001 OR'd with bits 8:5 of register 4.
- R11: While the link is up, register 18 has bit 10 set if register 4 has bit 7 or bit 8 set, and bit 11 set if register 4 has bit 8 or bit 6 set. All its other bits are 0. While the link is down, register 18 reads 0.
- R12: The write-data register (bus word 2) and the read-data register each keep the low 16 bits of a CPU write and read back zero-extended. Bus words 4 and above read 0 and ignore writes. After reset, all CPU registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | BUS_AW | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| phy_link_i | input | 1 | Link state of the emulated PHY |
| cfg_err_o | output | 1 | Enable set with a zero clock divider |

## Verification
Two things can happen on the same clock edge: a PHY write stores its data, and the same write force-clears the reset and restart bits of register 0. The bench writes 0xFFFF into register 0 and expects 0x7DFF back, which shows the store and the clear did not override each other. The second overlap is a change of link state landing in the same cycle as a read command for register 1 or 18. The link input is flipped just before the command edge, and the read-data register must hold the value for the new link state.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int PHY_AW  = 5;
    localparam int REG_AW  = 5;
    localparam int MD_W    = 16;
    localparam int REG_CNT = 1 << REG_AW;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_RSVD  = 2'd3
    } mgmt_op_e;

    typedef struct packed {
        logic [PHY_AW-1:0] phy;
        logic [REG_AW-1:0] regsel;
        mgmt_op_e          op;
        logic              go;
    } mgmt_cmd_t;

    // bus word indices
    localparam int CSR_CFG   = 0;
    localparam int CSR_CMD   = 1;
    localparam int CSR_WDATA = 2;
    localparam int CSR_RDATA = 3;

    localparam logic [31:0]     CMD_READY   = 32'h0000_0080;
    localparam logic [MD_W-1:0] ABSENT_DATA = 16'hFFFF;
    localparam logic [MD_W-1:0] CTL_SCLR    = 16'h8200;
    localparam logic [MD_W-1:0] STAT_UP     = 16'h782E;
    localparam logic [MD_W-1:0] PART_BASE   = 16'h4001;
    localparam logic [MD_W-1:0] ADV_MODES   = 16'h01E0;

    function automatic mgmt_cmd_t decode_cmd(input logic [31:0] w);
        mgmt_cmd_t c;
        c.phy    = w[28:24];
        c.regsel = w[20:16];
        c.op     = mgmt_op_e'(w[15:14]);
        c.go     = w[11];
        return c;
    endfunction

    function automatic logic [MD_W-1:0] phy_reset_val(input int idx);
        case (idx)
            0:       return 16'h3100;
            2:       return 16'h0300;
            3:       return 16'hE400;
            4:       return 16'h01E1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [MD_W-1:0] diag_word(input logic [MD_W-1:0] adv);
        logic [MD_W-1:0] d;
        d     = '0;
        d[10] = adv[7] | adv[8];
        d[11] = adv[8] | adv[6];
        return d;
    endfunction

endpackage

// File: rtl/mgmt_phy_model.sv
module mgmt_phy_model
    import mgmt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              link_i,
    input  logic              wr_en_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [MD_W-1:0]   wdata_i,
    output logic [MD_W-1:0]   rdata_o
);

    logic [MD_W-1:0] regs_q [REG_CNT];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < REG_CNT; i++) regs_q[i] <= phy_reset_val(i);
        end else if (wr_en_i) begin
            if (addr_i == '0) begin
                regs_q[0] <= wdata_i & ~CTL_SCLR;
            end else begin
                regs_q[addr_i] <= wdata_i;
                regs_q[0]      <= regs_q[0] & ~CTL_SCLR;
            end
        end
    end

    always_comb begin
        case (addr_i)
            5'd1:    rdata_o = link_i ? STAT_UP : '0;
            5'd5:    rdata_o = PART_BASE | (regs_q[4] & ADV_MODES);
            5'd18:   rdata_o = link_i ? diag_word(regs_q[4]) : '0;
            default: rdata_o = regs_q[addr_i];
        endcase
    end

    // R8
    ctl_selfclr_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_en_i |=> (regs_q[0][15] == 1'b0 && regs_q[0][9] == 1'b0));

    // R9
    link_down_stat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!link_i && addr_i == 5'd1) |-> rdata_o == '0);

    // R10
    partner_fixed_bits_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (addr_i == 5'd5) |-> (rdata_o[14] && rdata_o[0] && rdata_o[4:1] == '0));

endmodule

// File: rtl/mgmt_csr.sv
module mgmt_csr
    import mgmt_pkg::*;
#(
    parameter int          BUS_AW   = 4,
    parameter logic [4:0]  PHY_ADDR = 5'd7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_we_i,
    output logic [31:0]       bus_rdata_o,
    output logic              cfg_err_o,
    output logic              xfer_wr_o,
    output logic [REG_AW-1:0] xfer_reg_o,
    output logic [MD_W-1:0]   xfer_wdata_o,
    input  logic [MD_W-1:0]   xfer_rdata_i
);

    localparam logic [BUS_AW-1:0] A_CFG   = BUS_AW'(CSR_CFG);
    localparam logic [BUS_AW-1:0] A_CMD   = BUS_AW'(CSR_CMD);
    localparam logic [BUS_AW-1:0] A_WDATA = BUS_AW'(CSR_WDATA);
    localparam logic [BUS_AW-1:0] A_RDATA = BUS_AW'(CSR_RDATA);

    logic [6:0]      cfg_q;
    logic [31:0]     cmd_q;
    logic [MD_W-1:0] wdata_q;
    logic [MD_W-1:0] rdata_q;

    mgmt_cmd_t cmd_in;
    logic      cmd_wr, present, do_read;

    assign cmd_in  = decode_cmd(bus_wdata_i);
    assign cmd_wr  = bus_we_i && (bus_addr_i == A_CMD);
    assign present = (cmd_in.phy == PHY_ADDR);
    assign do_read = cmd_wr && cmd_in.go && (cmd_in.op == OP_READ);

    assign xfer_wr_o    = cmd_wr && cmd_in.go && (cmd_in.op == OP_WRITE) && present;
    assign xfer_reg_o   = cmd_in.regsel;
    assign xfer_wdata_o = wdata_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_q   <= '0;
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (bus_we_i && bus_addr_i == A_CFG)   cfg_q   <= bus_wdata_i[6:0];
            if (cmd_wr)                            cmd_q   <= bus_wdata_i;
            if (bus_we_i && bus_addr_i == A_WDATA) wdata_q <= bus_wdata_i[MD_W-1:0];
            if (do_read)
                rdata_q <= present ? xfer_rdata_i : ABSENT_DATA;
            else if (bus_we_i && bus_addr_i == A_RDATA)
                rdata_q <= bus_wdata_i[MD_W-1:0];
        end
    end

    assign cfg_err_o = cfg_q[6] && (cfg_q[5:0] == '0);

    always_comb begin
        case (bus_addr_i)
            A_CFG:   bus_rdata_o = {25'd0, cfg_q};
            A_CMD:   bus_rdata_o = cmd_q | CMD_READY;
            A_WDATA: bus_rdata_o = {16'd0, wdata_q};
            A_RDATA: bus_rdata_o = {16'd0, rdata_q};
            default: bus_rdata_o = '0;
        endcase
    end

    // R3
    no_xfer_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_wr && !(cmd_in.go && cmd_in.op == OP_READ)) |=> $stable(rdata_q));

    // R4
    absent_read_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (do_read && cmd_in.phy != PHY_ADDR) |=> rdata_q == ABSENT_DATA);

    // R5
    cmd_ready_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_addr_i == A_CMD) |-> bus_rdata_o[7]);

    // R6
    cfg_err_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_we_i && bus_addr_i == A_CFG) |=>
            cfg_err_o == ($past(bus_wdata_i[6]) && $past(bus_wdata_i[5:0]) == 6'd0));

endmodule

// File: rtl/mdio_mgmt_top.sv
module mdio_mgmt_top
    import mgmt_pkg::*;
#(
    parameter int          BUS_AW   = 4,
    parameter logic [4:0]  PHY_ADDR = 5'd7
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [BUS_AW-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic              bus_we_i,
    output logic [31:0]       bus_rdata_o,
    input  logic              phy_link_i,
    output logic              cfg_err_o
);

    logic              xfer_wr;
    logic [REG_AW-1:0] xfer_reg;
    logic [MD_W-1:0]   xfer_wdata;
    logic [MD_W-1:0]   xfer_rdata;

    mgmt_csr #(
        .BUS_AW   (BUS_AW),
        .PHY_ADDR (PHY_ADDR)
    ) u_csr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_we_i     (bus_we_i),
        .bus_rdata_o  (bus_rdata_o),
        .cfg_err_o    (cfg_err_o),
        .xfer_wr_o    (xfer_wr),
        .xfer_reg_o   (xfer_reg),
        .xfer_wdata_o (xfer_wdata),
        .xfer_rdata_i (xfer_rdata)
    );

    mgmt_phy_model u_phy (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .link_i  (phy_link_i),
        .wr_en_i (xfer_wr),
        .addr_i  (xfer_reg),
        .wdata_i (xfer_wdata),
        .rdata_o (xfer_rdata)
    );

endmodule

// File: tb/mdio_mgmt_top_tb.sv
module mdio_mgmt_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata;
    logic        link = 1'b1;
    logic        cfg_err;

    int total = 0;
    int bad   = 0;
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_top dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_we_i    (we),
        .bus_rdata_o (rdata),
        .phy_link_i  (link),
        .cfg_err_o   (cfg_err)
    );

    // {phy addr, reg addr, expected read} after reset, link up
    localparam logic [31:0] RST_VEC [10] = '{
        {8'd7,  8'd0,  16'h3100},   // R7
        {8'd7,  8'd2,  16'h0300},   // R7
        {8'd7,  8'd3,  16'hE400},   // R7
        {8'd7,  8'd4,  16'h01E1},   // R7
        {8'd7,  8'd6,  16'h0000},   // R7
        {8'd7,  8'd1,  16'h782E},   // R9
        {8'd7,  8'd5,  16'h41E1},   // R10
        {8'd7,  8'd18, 16'h0C00},   // R11
        {8'd3,  8'd0,  16'hFFFF},   // R4
        {8'd31, 8'd1,  16'hFFFF}    // R4
    };

    function automatic logic [31:0] mk_cmd(input logic [4:0] pa, input logic [4:0] ra,
                                           input logic [1:0] op, input logic go);
        return {3'b0, pa, 3'b0, ra, op, 2'b0, go, 11'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 rd_val = rdata;
    endtask

    task automatic phy_wr(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
        bus_wr(4'd2, {16'd0, d});
        bus_wr(4'd1, mk_cmd(pa, ra, 2'd1, 1'b1));
    endtask

    task automatic phy_rd(input logic [4:0] pa, input logic [4:0] ra);
        bus_wr(4'd1, mk_cmd(pa, ra, 2'd2, 1'b1));
        bus_rd(4'd3);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R12 / R5 reset state of CPU registers
        bus_rd(4'd0); check("R12 cfg reset", rd_val, 32'h0);
        bus_rd(4'd1); check("R5 cmd reset", rd_val, 32'h80);
        bus_rd(4'd2); check("R12 wdata reset", rd_val, 32'h0);
        bus_rd(4'd3); check("R12 rdata reset", rd_val, 32'h0);
        check("R6 cfg_err reset", {31'd0, cfg_err}, 32'h0);

        // table walk of PHY reset contents
        for (int i = 0; i < 10; i++) begin
            phy_rd(RST_VEC[i][28:24], RST_VEC[i][20:16]);
            check($sformatf("R7/R9/R10/R11/R4 vec%0d", i), rd_val, {16'd0, RST_VEC[i][15:0]});
        end

        // R6 configuration masking and error flag
        bus_wr(4'd0, 32'hFFFF_FFC0);
        bus_rd(4'd0); check("R6 cfg mask", rd_val, 32'h40);
        check("R6 cfg_err set", {31'd0, cfg_err}, 32'h1);
        bus_wr(4'd0, 32'h0000_0045);
        bus_rd(4'd0); check("R6 cfg value", rd_val, 32'h45);
        check("R6 cfg_err clear", {31'd0, cfg_err}, 32'h0);

        // R5 command readback
        bus_wr(4'd1, 32'h1234_5678);
        bus_rd(4'd1); check("R5 cmd readback", rd_val, 32'h1234_56F8);

        // R12 data registers and unmapped words
        bus_wr(4'd2, 32'hFFFF_5555);
        bus_rd(4'd2); check("R12 wdata low half", rd_val, 32'h5555);
        bus_wr(4'd3, 32'hABCD_1234);
        bus_rd(4'd3); check("R12 rdata low half", rd_val, 32'h1234);
        bus_wr(4'd5, 32'hDEAD_BEEF);
        bus_rd(4'd5); check("R12 unmapped read", rd_val, 32'h0);

        // R1 / R2 write then read back
        phy_wr(5'd7, 5'd9, 16'h1234);
        phy_rd(5'd7, 5'd9); check("R1 write reg9", rd_val, 32'h1234);

        // R10 / R11 derived registers follow advertisement
        phy_wr(5'd7, 5'd4, 16'h0040);
        phy_rd(5'd7, 5'd5);  check("R10 adv 10full", rd_val, 32'h4041);
        phy_rd(5'd7, 5'd18); check("R11 adv 10full", rd_val, 32'h0800);
        phy_wr(5'd7, 5'd4, 16'h0080);
        phy_rd(5'd7, 5'd18); check("R11 adv 100half", rd_val, 32'h0400);
        phy_wr(5'd7, 5'd4, 16'h0000);
        phy_rd(5'd7, 5'd5);  check("R10 adv none", rd_val, 32'h4001);
        phy_rd(5'd7, 5'd18); check("R11 adv none", rd_val, 32'h0000);

        // R8 store and self-clear on the same edge
        phy_wr(5'd7, 5'd0, 16'hFFFF);
        phy_rd(5'd7, 5'd0); check("R8 reg0 selfclear", rd_val, 32'h7DFF);

        // R4 write to absent PHY changes nothing
        phy_wr(5'd3, 5'd4, 16'h1111);
        phy_rd(5'd7, 5'd4); check("R4 absent write", rd_val, 32'h0000);

        // R3 no transaction without start or with bad opcode
        phy_rd(5'd7, 5'd2); check("R2 load reg2", rd_val, 32'h0300);
        bus_wr(4'd1, mk_cmd(5'd7, 5'd3, 2'd3, 1'b1));
        bus_rd(4'd3); check("R3 op3 hold", rd_val, 32'h0300);
        bus_wr(4'd1, mk_cmd(5'd7, 5'd3, 2'd0, 1'b1));
        bus_rd(4'd3); check("R3 op0 hold", rd_val, 32'h0300);
        bus_wr(4'd1, mk_cmd(5'd7, 5'd3, 2'd2, 1'b0));
        bus_rd(4'd3); check("R3 no start read", rd_val, 32'h0300);
        bus_wr(4'd2, 32'h0000_BEEF);
        bus_wr(4'd1, mk_cmd(5'd7, 5'd6, 2'd1, 1'b0));
        bus_wr(4'd1, mk_cmd(5'd7, 5'd6, 2'd3, 1'b1));
        phy_rd(5'd7, 5'd6); check("R3 no start write", rd_val, 32'h0000);

        // R9 / R11 link change right before the read command edge
        phy_wr(5'd7, 5'd4, 16'h01E1);
        @(negedge clk) link = 1'b0;
        phy_rd(5'd7, 5'd1);  check("R9 link down stat", rd_val, 32'h0000);
        phy_rd(5'd7, 5'd18); check("R11 link down diag", rd_val, 32'h0000);
        @(negedge clk) link = 1'b1;
        phy_rd(5'd7, 5'd1);  check("R9 link up stat", rd_val, 32'h782E);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule